// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus in front of a byte-wide memory array of 128 to 2048 bytes. It runs on a fast system clock that oversamples the bus. SCL and SDA come in through synchronizers. The block drives SDA low through an open-drain enable (`sda_oe` = 1 pulls the line low) and never drives it high. It recognises bus START and STOP conditions and decodes a select byte that carries a fixed type code and a read/write flag. In the three bits between those fields it compares chip-enable straps or takes high memory address bits, depending on the `DENSITY_KBIT` parameter.

The supported transfers are:
- byte and page writes of up to 16 data bytes, gathered in a page buffer and written to the array at STOP;
- random reads, made of an address-only write followed by a repeated START;
- current-address reads;
- sequential reads.

After each commit the block stays busy for `WRITE_CYCLES` clocks and ignores the bus. A master can therefore poll for completion by repeating the select byte until it is acknowledged. A write-protect input blocks data bytes. Select and address bytes are still acknowledged while it is high.

The controller is a single state machine:
- **Idle**: waits for START.
- **Select**: shifts in the select byte.
- **SelectAck**: acknowledges the select byte on a match, otherwise releases SDA and drops to Idle.
- **Address**: shifts in the address byte.
- **AddrAck**: always acknowledges the address byte.
- **WrData**: shifts in a data byte.
- **WrDataAck**: acknowledges the data byte unless write-protect is high.
- **RdData**: shifts a byte out, MSB first.
- **RdAck**: samples the master's acknowledge.
- **Commit**: copies the valid page-buffer entries into the array, one clock per entry.
- **Busy**: counts the internal write time.

The transitions are:
- START in Idle or in any transfer state goes to Select.
- STOP at a byte boundary in WrData goes to Commit if at least one data byte was buffered.
- Any other STOP during a transfer goes to Idle.
- A completed byte at the SCL fall goes to the matching acknowledge state.
- Each acknowledge state moves on at the next SCL fall:
  - SelectAck goes to RdData or Address, depending on the read/write flag.
  - AddrAck goes to WrData.
  - WrDataAck goes back to WrData.
- RdData goes to RdAck after eight bits.
- RdAck goes to RdData when the master acknowledges, and to Idle when it does not.
- Commit goes to Busy after the last buffer entry.
- Busy goes to Idle when its count expires.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A select byte is acknowledged only if its four upper bits are 1010 and each of bits 3..1 that is not used as an address bit equals the matching `chip_en` bit. Bit 1 becomes address bit 8 at 4 Kbit, bits 2..1 become address bits 9..8 at 8 Kbit, and bits 3..1 become address bits 10..8 at 16 Kbit. A mismatched select byte gets no acknowledge.
- R2: SDA falling while SCL is high is a START. It always begins a new select byte and discards buffered write data. SDA rising while SCL is high is a STOP. A STOP in the middle of a data byte (two or more bits received) discards the write and returns to Idle.
- R3: After each accepted byte from the master, the slave holds SDA low for the whole ninth SCL pulse. Out of reset it does not drive SDA.
- R4: Read data leaves MSB first, and the slave changes SDA only after an SCL falling edge.
- R5: Data bytes after the address byte fill a page buffer. The address advances by one after each byte and wraps within its 16-byte page. The buffer is written to the array at a STOP on a byte boundary, and only if at least one data byte was taken.
- R6: While `wr_protect` is high, select and address bytes are acknowledged, data bytes are not, and the array is left unchanged.
- R7: For `WRITE_CYCLES` clocks after a commit the slave ignores the bus and does not acknowledge its select byte. Afterwards it acknowledges again.
- R8: An address-only write followed by a repeated START and a read select returns the byte at the written address.
- R9: A read continues with the next address for each byte the master acknowledges. The read address rolls over from the last array location to zero. A master no-acknowledge ends the read.
- R10: A read select without a preceding address returns the byte one past the last byte read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| chip_en | input | 3 | Strap value for select bits 3..1 |
| wr_protect | input | 1 | High refuses data bytes |

## Verification
The hardest situation to reach is a STOP that lands after a few bits of a data byte, because a normal master only stops at byte boundaries. The bench has a task that clocks out a partial byte and then issues the STOP. The only evidence that the abort worked is at the ports: the select byte sent right afterwards is acknowledged at once (no busy window), and a later read shows the old contents. The busy window is checked the same way, with one select attempt immediately after a commit and one after the window has elapsed. Sequential reads that cross both the end of a page and the end of the array are checked from a queue of expected bytes.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_COMMIT,
        ST_BUSY
    } slv_state_e;
endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_page_buf.sv
`timescale 1ns/1ps
module twi_page_buf #(
    parameter int PAGE_BYTES = 16,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [PW-1:0] raddr,
    output logic [7:0]    rdata,
    output logic          rvalid,
    output logic          any_valid
);
    logic [7:0]            ent_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] ent_valid;

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_ent
        logic [7:0] d_q;
        logic       v_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (we && waddr == PW'(i)) begin
                d_q <= wdata;
                v_q <= 1'b1;
            end
        end
        assign ent_data[i]  = d_q;
        assign ent_valid[i] = v_q;
    end

    assign rdata     = ent_data[raddr];
    assign rvalid    = ent_valid[raddr];
    assign any_valid = |ent_valid;
endmodule

// File: rtl/twi_mem_array.sv
`timescale 1ns/1ps
module twi_mem_array #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/twi_eeprom_slave.sv
`timescale 1ns/1ps
module twi_eeprom_slave
    import twi_pkg::*;
#(
    parameter int DENSITY_KBIT = 4,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 500,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] chip_en,
    input  logic       wr_protect
);
    localparam int MEM_BYTES = DENSITY_KBIT * 128;
    localparam int AW        = $clog2(MEM_BYTES);
    localparam int PW        = $clog2(PAGE_BYTES);
    localparam int HI_BITS   = (AW > 8) ? AW - 8 : 0;
    localparam logic [2:0] CE_MASK = 3'(7 << HI_BITS);
    localparam int BW        = $clog2(WRITE_CYCLES + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    slv_state_e state, nxt;
    logic [7:0]    shreg;
    logic [3:0]    bit_cnt;
    logic          ack_q, rw_q, mack_q;
    logic [2:0]    sel_hi;
    logic [AW-1:0] ptr;
    logic [PW-1:0] commit_idx;
    logic [BW-1:0] busy_cnt;

    logic          in_xfer, byte_done, sel_match;
    logic [10:0]   full_addr;
    logic          buf_clr, buf_we, buf_rvalid, buf_any;
    logic [7:0]    buf_rdata, mem_rdata;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
        .waddr(ptr[PW-1:0]), .wdata(shreg), .raddr(commit_idx),
        .rdata(buf_rdata), .rvalid(buf_rvalid), .any_valid(buf_any)
    );

    twi_mem_array #(.DEPTH(MEM_BYTES)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(buf_rdata),
        .raddr(ptr), .rdata(mem_rdata)
    );

    assign in_xfer   = (state inside {ST_SEL, ST_SEL_ACK, ST_ADDR, ST_ADDR_ACK,
                                      ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK});
    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign sel_match = (shreg[7:4] == 4'b1010) &&
                       (((shreg[3:1] ^ chip_en) & CE_MASK) == 3'b000);
    assign full_addr = {sel_hi, shreg};
    assign buf_clr   = start_det && (in_xfer || state == ST_IDLE);
    assign buf_we    = (state == ST_WDATA) && byte_done && !wr_protect;
    assign mem_we    = (state == ST_COMMIT) && buf_rvalid;
    assign mem_waddr = {ptr[AW-1:PW], commit_idx};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (in_xfer && start_det) begin
            nxt = ST_SEL;
        end else if (in_xfer && stop_det) begin
            nxt = (state == ST_WDATA && bit_cnt <= 4'd1 && buf_any) ? ST_COMMIT : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      if (start_det) nxt = ST_SEL;
                ST_SEL:       if (byte_done) nxt = ST_SEL_ACK;
                ST_SEL_ACK:   if (scl_fall)  nxt = !ack_q ? ST_IDLE : (rw_q ? ST_RDATA : ST_ADDR);
                ST_ADDR:      if (byte_done) nxt = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (scl_fall)  nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && bit_cnt == 4'd7) nxt = ST_RACK;
                ST_RACK:      if (scl_fall)  nxt = mack_q ? ST_RDATA : ST_IDLE;
                ST_COMMIT:    if (commit_idx == PW'(PAGE_BYTES - 1)) nxt = ST_BUSY;
                ST_BUSY:      if (busy_cnt == BW'(WRITE_CYCLES - 1)) nxt = ST_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            ack_q      <= 1'b0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            sel_hi     <= '0;
            ptr        <= '0;
            commit_idx <= '0;
            busy_cnt   <= '0;
        end else begin
            unique case (state)
                ST_SEL, ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        bit_cnt <= '0;
                        if (state == ST_SEL) begin
                            ack_q  <= sel_match;
                            rw_q   <= shreg[0];
                            sel_hi <= shreg[3:1];
                        end else if (state == ST_ADDR) begin
                            ack_q <= 1'b1;
                            ptr   <= AW'(full_addr);
                        end else begin
                            ack_q <= !wr_protect;
                            if (!wr_protect)
                                ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
                        end
                    end
                end
                ST_SEL_ACK: begin
                    if (scl_fall && ack_q && rw_q) begin
                        shreg   <= mem_rdata;
                        bit_cnt <= '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            bit_cnt <= '0;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b1};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_q <= !sda_s;
                        ptr    <= ptr + AW'(1);
                    end
                    if (scl_fall && mack_q) shreg <= mem_rdata;
                end
                ST_COMMIT: commit_idx <= commit_idx + PW'(1);
                ST_BUSY:   busy_cnt <= (busy_cnt == BW'(WRITE_CYCLES - 1)) ? '0 : busy_cnt + BW'(1);
                ST_IDLE, ST_ADDR_ACK, ST_WDATA_ACK: ;
            endcase
            if (buf_clr) bit_cnt <= '0;
        end
    end

    // output logic
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_SEL_ACK, ST_ADDR_ACK, ST_WDATA_ACK: sda_oe = ack_q;
            ST_RDATA:                              sda_oe = !shreg[7];
            default:                               sda_oe = 1'b0;
        endcase
    end

    // assertions
    assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> !sda_oe);

    assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> (busy_cnt < BW'(WRITE_CYCLES)));

    assert_commit_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && $past(state) != ST_COMMIT) |-> buf_any);

    assert_start_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && (in_xfer || state == ST_IDLE)) |=> (state == ST_SEL));

    assert_read_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && $past(state) == ST_RDATA && !$stable(sda_oe)) |-> $past(scl_fall));

    assert_wp_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA_ACK && $past(wr_protect) && $past(state) == ST_WDATA) |-> !sda_oe);
endmodule

// File: tb/twi_eeprom_slave_test.sv
`timescale 1ns/1ps
module twi_eeprom_slave_test;
    localparam int H  = 8;
    localparam int WR = 500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [2:0] straps = 3'b010;

    int checks = 0;
    int fails = 0;
    int r4_viol = 0;
    logic prev_oe = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_byte;
    event       obs_ev;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    twi_eeprom_slave #(.DENSITY_KBIT(4), .PAGE_BYTES(16), .WRITE_CYCLES(WR), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .chip_en(straps), .wr_protect(wp)
    );

    // R4 monitor: SDA drive may only change while SCL is low
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && scl_m) r4_viol++;
        prev_oe = sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected byte", obs_byte, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(obs_byte === e, t, obs_byte, e);
            end
        end
    end

    task automatic expect_byte(input logic [7:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H/2);
        ack = (sda_line == 1'b0);
        tick(H/2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input bit mack);
        logic [7:0] b;
        b = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(H);
            scl_m = 1'b1; tick(H/2);
            b = {b[6:0], sda_line};
            tick(H/2);
            scl_m = 1'b0;
        end
        sda_m = mack ? 1'b0 : 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1;
        obs_byte = b;
        -> obs_ev;
        tick(1);
    endtask

    function automatic logic [7:0] sel(input bit a8, input bit rw);
        return {4'b1010, 1'b0, 1'b1, a8, rw};
    endfunction

    task automatic write_page(input int addr, input int n, input int base);
        bit a;
        bus_start();
        send_byte(sel(addr[8], 1'b0), a); check(a, "R1 R3 select ack", a, 1);
        send_byte(addr[7:0], a);          check(a, "R3 address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(8'(base + i), a);   check(a, "R5 data ack", a, 1);
        end
        bus_stop();
    endtask

    task automatic read_from(input int addr, input int n);
        bit a;
        bus_start();
        send_byte(sel(addr[8], 1'b0), a); check(a, "R8 dummy select ack", a, 1);
        send_byte(addr[7:0], a);          check(a, "R8 address ack", a, 1);
        bus_start();
        send_byte(sel(1'b0, 1'b1), a);    check(a, "R8 read select ack", a, 1);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        bit a;
        tick(5);
        check(sda_oe == 1'b0, "R3 reset release", sda_oe, 0);
        rst_n = 1'b1;
        tick(5);

        // R1: wrong type code and wrong strap are refused
        bus_start();
        send_byte(8'hB4, a); check(!a, "R1 type mismatch nack", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1010, 3'b000, 1'b0}, a); check(!a, "R1 strap mismatch nack", a, 0);
        bus_stop();

        // R5 page write, then R7 busy polling
        write_page(9'h000, 4, 8'h10);
        bus_start();
        send_byte(sel(1'b0, 1'b0), a); check(!a, "R7 busy nack", a, 0);
        bus_stop();
        tick(WR + 100);
        bus_start();
        send_byte(sel(1'b0, 1'b0), a); check(a, "R7 ready ack", a, 1);
        bus_stop();
        bus_start();
        send_byte(sel(1'b0, 1'b0), a); check(a, "R5 empty write no busy", a, 1);
        bus_stop();

        write_page(9'h1F0, 16, 8'h40);
        tick(WR + 100);
        write_page(9'h1FC, 6, 8'h80);   // R5 wraps inside the page
        tick(WR + 100);

        // R6 write protect
        wp = 1'b1;
        bus_start();
        send_byte(sel(1'b0, 1'b0), a); check(a, "R6 select ack under protect", a, 1);
        send_byte(8'h00, a);           check(a, "R6 address ack under protect", a, 1);
        send_byte(8'hEE, a);           check(!a, "R6 data nack under protect", a, 0);
        bus_stop();
        wp = 1'b0;
        bus_start();
        send_byte(sel(1'b0, 1'b0), a); check(a, "R6 no commit after protect", a, 1);
        bus_stop();

        // R2 STOP mid-byte aborts
        bus_start();
        send_byte(sel(1'b0, 1'b0), a); check(a, "R2 select ack", a, 1);
        send_byte(8'h01, a);           check(a, "R2 address ack", a, 1);
        send_byte(8'h77, a);           check(a, "R2 data ack", a, 1);
        send_bits(8'hA0, 3);
        bus_stop();
        bus_start();
        send_byte(sel(1'b0, 1'b0), a); check(a, "R2 abort left no busy", a, 1);
        bus_stop();

        // R8/R9 random then sequential read across page end and array end
        expect_byte(8'h84, "R8 R5 wrapped byte 1F0");
        expect_byte(8'h85, "R9 R5 wrapped byte 1F1");
        for (int i = 2; i < 12; i++) expect_byte(8'(8'h40 + i), "R9 page byte");
        for (int i = 0; i < 4; i++)  expect_byte(8'(8'h80 + i), "R9 R5 tail byte");
        expect_byte(8'h10, "R9 R6 rollover byte 000");
        expect_byte(8'h11, "R9 R2 byte 001");
        expect_byte(8'h12, "R9 byte 002");
        read_from(9'h1F0, 19);

        // R10 current address read
        expect_byte(8'h13, "R10 current address");
        bus_start();
        send_byte(sel(1'b1, 1'b1), a); check(a, "R10 read select ack", a, 1);
        recv_byte(1'b0);
        bus_stop();

        // single byte write and random read back
        write_page(9'h105, 1, 8'hA5);
        tick(WR + 100);
        expect_byte(8'hA5, "R8 random read 105");
        read_from(9'h105, 1);

        tick(20);
        check(r4_viol == 0, "R4 SDA changed while SCL high", r4_viol, 0);
        check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule